// File: doc/BRIEF.md
# MDIO Management Master

This block is the management side of a clause-22 MDIO link. The system clock is divided to produce the management clock, MDC. A single request (PHY address, register address, direction and write data) is turned into a serial frame on a tri-state data line, which the block presents as an output, an output enable and an input. For reads it returns the sixteen data bits shifted in from the PHY, and it also reports whether the PHY pulled the line low during the turnaround.

One 32-bit control/status word configures the block. It holds the MDC divider, the enable, the preamble suppression, the fault-detection enable, and a sticky fault flag that is cleared by writing one. The same word shows the engine's idle state and a fixed field giving the highest user channel. Clearing the enable never cuts a frame short: the frame in flight runs to its end before the engine reports idle. When fault detection is on, the block compares every bit it drives with what comes back on the input. A mismatch aborts the frame and raises the flag.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the status word reads 0x810000FF: idle (bit 31) is 1, the channel field (bits 28:24) is 1, the divider (bits 15:0) is 0xFF, and all other bits are 0.
- R2: A write stores enable at bit 30, preamble-off at bit 20, fault-detect enable at bit 18 and the divider at bits 15:0, and these read back in the same positions. Bits 29, 23:21 and 17:16 always read 0, and bits 28:24 always read 1.
- R3: With a divider value D of 1 or more, MDC has a period of D+1 system clocks. With D equal to 0, MDC stays low.
- R4: With preamble-off at 0, a frame is 64 MDC periods long. It is 32 ones followed by start 01, an opcode (01 write, 10 read), a 5-bit PHY address, a 5-bit register address, a turnaround, and 16 data bits, all MSB first. On a write the turnaround is 10 and every bit is driven. The data output changes only on falling MDC edges.
- R5: With preamble-off at 1, the frame starts directly with the start bits and lasts 32 MDC periods.
- R6: On a read the block drives the first 14 frame bits and releases the line for the turnaround and data. It samples the input on rising MDC edges and returns the 16 data bits MSB first. The acknowledge output is 1 exactly when the input was 0 during the second turnaround bit.
- R7: A go request is accepted only while the enable is 1 and the engine is idle. Otherwise it is ignored and no frame starts.
- R8: If the enable is cleared during a frame, that frame still completes with done. Idle reads 0 while the frame is in progress and 1 after it.
- R9: With fault detection enabled, if a driven bit is sampled back with the wrong value, the fault flag (bit 19) is set, the frame is abandoned without done, the line is released and the engine is idle.
- R10: The fault flag is cleared only by writing 1 to bit 19. Writing 0 there leaves it set.
- R11: With fault detection disabled, readback mismatches are ignored: the frame completes with done and the fault flag stays 0.
- R12: Done is a pulse one system clock wide at the end of each completed frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Write strobe for the control word |
| csr_wdata | input | 32 | Control word write value |
| csr_rdata | output | 32 | Control/status word read value |
| usr_go | input | 1 | Start request |
| usr_read | input | 1 | 1 for a read frame, 0 for a write frame |
| usr_phy | input | 5 | PHY address |
| usr_reg | input | 5 | Register address |
| usr_wdata | input | 16 | Write data |
| usr_rdata | output | 16 | Read data, valid with done |
| usr_ack | output | 1 | PHY acknowledged the read |
| usr_done | output | 1 | Frame completed |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The bench captures every frame bit by bit at the falling MDC edges. A preamble sent while it is suppressed, or left out while it is wanted, shifts every later bit and shows up at once. A read that keeps driving through the turnaround is caught by the captured enable bits, and a wrong edge choice for sampling garbles the returned data. Faults are injected by flipping the readback in the middle of a write. A design that completes the frame anyway, clears the flag on a zero write, or flags mismatches with detection off fails those scenarios. The bench also drops the enable during a frame: a design that aborts the frame there never raises done.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int CSR_W   = 32;
    localparam int DIV_W   = 16;
    localparam int PHY_AW  = 5;
    localparam int REG_AW  = 5;
    localparam int DATA_W  = 16;
    localparam int PRE_LEN = 32;
    localparam int CH_W    = 5;

    localparam logic [CH_W-1:0]  TOP_CHANNEL = 5'd1;
    localparam logic [DIV_W-1:0] DIV_RESET   = 16'h00FF;

    // Bit positions in the control/status word
    localparam int POS_IDLE     = 31;
    localparam int POS_EN       = 30;
    localparam int POS_CH_LO    = 24;
    localparam int POS_PRE_OFF  = 20;
    localparam int POS_FAULT    = 19;
    localparam int POS_FAULT_EN = 18;

    // Frame geometry after the preamble
    localparam int FRAME_LEN = 4 + PHY_AW + REG_AW + 2 + DATA_W;
    localparam int TA_POS    = 4 + PHY_AW + REG_AW;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_ARM   = 2'd1,
        ENG_SHIFT = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic             enable;
        logic             pre_off;
        logic             fault_en;
        logic [DIV_W-1:0] div;
    } ctrl_t;

    typedef struct packed {
        logic              is_read;
        logic [PHY_AW-1:0] phy;
        logic [REG_AW-1:0] regad;
        logic [DATA_W-1:0] wdata;
    } req_t;

    function automatic logic [FRAME_LEN-1:0] build_frame(input req_t r);
        logic [1:0]        op;
        logic [1:0]        ta;
        logic [DATA_W-1:0] d;
        op = r.is_read ? 2'b10 : 2'b01;
        ta = r.is_read ? 2'b11 : 2'b10;
        d  = r.is_read ? {DATA_W{1'b1}} : r.wdata;
        return {2'b01, op, r.phy, r.regad, ta, d};
    endfunction

    function automatic logic [CSR_W-1:0] pack_status(input ctrl_t c, input logic idle,
                                                     input logic fault);
        logic [CSR_W-1:0] w;
        w                      = '0;
        w[POS_IDLE]            = idle;
        w[POS_EN]              = c.enable;
        w[POS_CH_LO +: CH_W]   = TOP_CHANNEL;
        w[POS_PRE_OFF]         = c.pre_off;
        w[POS_FAULT]           = fault;
        w[POS_FAULT_EN]        = c.fault_en;
        w[DIV_W-1:0]           = c.div;
        return w;
    endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div
    import mdio_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] div_i,
    output logic         mdc_o,
    output logic         rise_o,
    output logic         fall_o
);

    logic [W-1:0] cnt_q;
    logic         run;
    logic [W:0]   half_m1;

    always_comb begin
        run     = |div_i;
        half_m1 = (({1'b0, div_i} + 1'b1) >> 1) - 1'b1;
        rise_o  = run && (cnt_q >= div_i);
        fall_o  = run && ({1'b0, cnt_q} == half_m1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            mdc_o <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc_o <= 1'b0;
        end else begin
            cnt_q <= rise_o ? '0 : cnt_q + 1'b1;
            if (rise_o)
                mdc_o <= 1'b1;
            else if (fall_o)
                mdc_o <= 1'b0;
        end
    end

    // R3: a zero divider parks MDC low
    assert_mdc_parked_R3: assert property (@(posedge clk) disable iff (rst)
        (div_i == '0) |=> !mdc_o);

    // R3: MDC only rises on a rising tick
    assert_mdc_rise_tick_R3: assert property (@(posedge clk) disable iff (rst)
        (!mdc_o && !rise_o) |=> !mdc_o);

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
#(
    parameter int PRE_BITS = PRE_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              pre_off_i,
    input  logic              fault_en_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              go_i,
    input  req_t              req_i,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              idle_o,
    output logic              done_o,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              fault_set_o
);

    localparam int PRE_CW = $clog2(PRE_BITS + 1);
    localparam int POS_W  = $clog2(FRAME_LEN + 1);

    localparam logic [POS_W-1:0]  POS_LAST = POS_W'(FRAME_LEN);
    localparam logic [POS_W-1:0]  DRV_END  = POS_W'(TA_POS);
    localparam logic [POS_W-1:0]  ACK_POS  = POS_W'(TA_POS + 2);
    localparam logic [POS_W-1:0]  DATA_POS = POS_W'(TA_POS + 3);
    localparam logic [PRE_CW-1:0] PRE_INIT = PRE_CW'(PRE_BITS);

    eng_state_e           st_q;
    logic [FRAME_LEN-1:0] sh_q;
    logic                 rd_q;
    logic [PRE_CW-1:0]    pre_q;
    logic [POS_W-1:0]     pos_q;

    logic accept;
    logic mismatch;
    logic last_bit;

    assign accept   = go_i && en_i && (st_q == ENG_IDLE);
    assign mismatch = fault_en_i && mdio_oe && (mdio_i != mdio_o);
    assign last_bit = (pre_q == '0) && (pos_q == POS_LAST);
    assign idle_o   = (st_q == ENG_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ENG_IDLE;
            sh_q        <= '0;
            rd_q        <= 1'b0;
            pre_q       <= '0;
            pos_q       <= '0;
            mdio_o      <= 1'b1;
            mdio_oe     <= 1'b0;
            done_o      <= 1'b0;
            ack_o       <= 1'b0;
            rdata_o     <= '0;
            fault_set_o <= 1'b0;
        end else begin
            done_o      <= 1'b0;
            fault_set_o <= 1'b0;
            case (st_q)
                ENG_IDLE: begin
                    if (accept) begin
                        sh_q    <= build_frame(req_i);
                        rd_q    <= req_i.is_read;
                        pre_q   <= pre_off_i ? '0 : PRE_INIT;
                        pos_q   <= '0;
                        ack_o   <= 1'b0;
                        rdata_o <= '0;
                        st_q    <= ENG_ARM;
                    end
                end
                ENG_ARM, ENG_SHIFT: begin
                    if (fall_i) begin
                        st_q <= ENG_SHIFT;
                        if (pre_q != '0) begin
                            mdio_o  <= 1'b1;
                            mdio_oe <= 1'b1;
                            pre_q   <= pre_q - 1'b1;
                        end else begin
                            mdio_o  <= sh_q[FRAME_LEN-1];
                            mdio_oe <= !rd_q || (pos_q < DRV_END);
                            sh_q    <= sh_q << 1;
                            pos_q   <= pos_q + 1'b1;
                        end
                    end else if (rise_i && (st_q == ENG_SHIFT)) begin
                        if (mismatch) begin
                            st_q        <= ENG_IDLE;
                            mdio_oe     <= 1'b0;
                            fault_set_o <= 1'b1;
                        end else begin
                            if (rd_q && (pos_q == ACK_POS))
                                ack_o <= !mdio_i;
                            if (rd_q && (pos_q >= DATA_POS))
                                rdata_o <= {rdata_o[DATA_W-2:0], mdio_i};
                            if (last_bit) begin
                                st_q    <= ENG_IDLE;
                                mdio_oe <= 1'b0;
                                done_o  <= 1'b1;
                            end
                        end
                    end
                end
                default: st_q <= ENG_IDLE;
            endcase
        end
    end

    // R12: done never lasts two cycles
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8: the line is only driven while a frame is in flight
    assert_oe_busy_R8: assert property (@(posedge clk) disable iff (rst)
        mdio_oe |-> !idle_o);

    // R7: a request while disabled starts nothing
    assert_go_gated_R7: assert property (@(posedge clk) disable iff (rst)
        (go_i && !en_i && idle_o) |=> idle_o);

    // R4: data output moves only on a falling MDC tick
    assert_drive_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
        (mdio_o != $past(mdio_o)) |-> $past(fall_i));

    // R9: a detected fault leaves the engine idle with the line released
    assert_fault_abort_R9: assert property (@(posedge clk) disable iff (rst)
        fault_set_o |-> (idle_o && !mdio_oe && !done_o));

endmodule

// File: rtl/mdio_csr.sv
module mdio_csr
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic [CSR_W-1:0] wdata_i,
    input  logic             idle_i,
    input  logic             fault_set_i,
    output ctrl_t            ctrl_o,
    output logic             fault_o,
    output logic [CSR_W-1:0] rdata_o
);

    logic unused_wbits;
    assign unused_wbits = ^{wdata_i[POS_IDLE], wdata_i[29:21], wdata_i[17:16]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_o.enable   <= 1'b0;
            ctrl_o.pre_off  <= 1'b0;
            ctrl_o.fault_en <= 1'b0;
            ctrl_o.div      <= DIV_RESET;
            fault_o         <= 1'b0;
        end else begin
            if (wr_i) begin
                ctrl_o.enable   <= wdata_i[POS_EN];
                ctrl_o.pre_off  <= wdata_i[POS_PRE_OFF];
                ctrl_o.fault_en <= wdata_i[POS_FAULT_EN];
                ctrl_o.div      <= wdata_i[DIV_W-1:0];
            end
            if (fault_set_i)
                fault_o <= 1'b1;
            else if (wr_i && wdata_i[POS_FAULT])
                fault_o <= 1'b0;
        end
    end

    assign rdata_o = pack_status(ctrl_o, idle_i, fault_o);

    // R10: flag survives anything but a write of one
    assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (fault_o && !(wr_i && wdata_i[POS_FAULT])) |=> fault_o);

    // R10: a write of one clears the flag when no new fault arrives
    assert_fault_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_i && wdata_i[POS_FAULT] && !fault_set_i) |=> !fault_o);

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_pkg::*;
#(
    parameter int PRE_BITS = PRE_LEN
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                csr_wr,
    input  logic [CSR_W-1:0]    csr_wdata,
    output logic [CSR_W-1:0]    csr_rdata,
    input  logic                usr_go,
    input  logic                usr_read,
    input  logic [PHY_AW-1:0]   usr_phy,
    input  logic [REG_AW-1:0]   usr_reg,
    input  logic [DATA_W-1:0]   usr_wdata,
    output logic [DATA_W-1:0]   usr_rdata,
    output logic                usr_ack,
    output logic                usr_done,
    output logic                mdc,
    output logic                mdio_o,
    output logic                mdio_oe,
    input  logic                mdio_i
);

    ctrl_t ctrl;
    req_t  req;
    logic  fault;
    logic  idle;
    logic  fault_set;
    logic  rise_tick;
    logic  fall_tick;

    logic unused_fault;
    assign unused_fault = fault;

    assign req.is_read = usr_read;
    assign req.phy     = usr_phy;
    assign req.regad   = usr_reg;
    assign req.wdata   = usr_wdata;

    mdio_csr u_csr (
        .clk         (clk),
        .rst         (rst),
        .wr_i        (csr_wr),
        .wdata_i     (csr_wdata),
        .idle_i      (idle),
        .fault_set_i (fault_set),
        .ctrl_o      (ctrl),
        .fault_o     (fault),
        .rdata_o     (csr_rdata)
    );

    mdio_clk_div #(.W(DIV_W)) u_div (
        .clk    (clk),
        .rst    (rst),
        .div_i  (ctrl.div),
        .mdc_o  (mdc),
        .rise_o (rise_tick),
        .fall_o (fall_tick)
    );

    mdio_frame_engine #(.PRE_BITS(PRE_BITS)) u_eng (
        .clk         (clk),
        .rst         (rst),
        .en_i        (ctrl.enable),
        .pre_off_i   (ctrl.pre_off),
        .fault_en_i  (ctrl.fault_en),
        .rise_i      (rise_tick),
        .fall_i      (fall_tick),
        .go_i        (usr_go),
        .req_i       (req),
        .mdio_i      (mdio_i),
        .mdio_o      (mdio_o),
        .mdio_oe     (mdio_oe),
        .idle_o      (idle),
        .done_o      (usr_done),
        .ack_o       (usr_ack),
        .rdata_o     (usr_rdata),
        .fault_set_o (fault_set)
    );

endmodule

// File: tb/mdio_mgmt_master_tb_top.sv
module mdio_mgmt_master_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_wr = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        usr_go = 1'b0;
    logic        usr_read = 1'b0;
    logic [4:0]  usr_phy = '0;
    logic [4:0]  usr_reg = '0;
    logic [15:0] usr_wdata = '0;
    logic [15:0] usr_rdata;
    logic        usr_ack;
    logic        usr_done;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i;
    logic        phy_bit = 1'b1;
    logic        inj = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit ended   = 0;

    logic [63:0] cap_o;
    logic [63:0] cap_oe;

    always #2 clk = ~clk;

    assign mdio_i = mdio_oe ? (mdio_o ^ inj) : phy_bit;

    mdio_mgmt_master dut_i (
        .clk       (clk),
        .rst       (rst),
        .csr_wr    (csr_wr),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .usr_go    (usr_go),
        .usr_read  (usr_read),
        .usr_phy   (usr_phy),
        .usr_reg   (usr_reg),
        .usr_wdata (usr_wdata),
        .usr_rdata (usr_rdata),
        .usr_ack   (usr_ack),
        .usr_done  (usr_done),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ctrl_word(input bit en, input bit pre_off,
                                              input bit fault_en, input bit clr,
                                              input logic [15:0] div);
        logic [31:0] w;
        w = {16'h0, div};
        w[30] = en;
        w[20] = pre_off;
        w[19] = clr;
        w[18] = fault_en;
        return w;
    endfunction

    function automatic logic [31:0] fbits(input bit rd, input logic [4:0] phy,
                                          input logic [4:0] rg, input logic [15:0] d);
        return {2'b01, (rd ? 2'b10 : 2'b01), phy, rg, (rd ? 2'b11 : 2'b10),
                (rd ? 16'hFFFF : d)};
    endfunction

    task automatic csr_write(input logic [31:0] v);
        @(negedge clk);
        csr_wr    = 1'b1;
        csr_wdata = v;
        @(negedge clk);
        csr_wr    = 1'b0;
    endtask

    task automatic csr_read(output logic [31:0] v);
        @(negedge clk);
        v = csr_rdata;
    endtask

    task automatic issue_go(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                            input logic [15:0] d);
        @(negedge clk);
        usr_read  = rd;
        usr_phy   = phy;
        usr_reg   = rg;
        usr_wdata = d;
        usr_go    = 1'b1;
        @(negedge clk);
        usr_go    = 1'b0;
    endtask

    task automatic capture(input int n, input logic [63:0] pat);
        cap_o  = '0;
        cap_oe = '0;
        wait (mdio_oe === 1'b1);
        #1;
        for (int b = 0; b < n; b++) begin
            if (b > 0) begin
                @(negedge mdc);
                #1;
            end
            phy_bit   = pat[b];
            cap_o[b]  = mdio_o;
            cap_oe[b] = mdio_oe;
        end
    endtask

    task automatic wait_done(output bit seen, output int width);
        seen  = 0;
        width = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (usr_done) begin
                seen  = 1;
                width = 1;
                @(negedge clk);
                if (usr_done) width = 2;
                break;
            end
        end
        phy_bit = 1'b1;
    endtask

    task automatic measure_period(output int n);
        bit prev;
        @(posedge mdc);
        #1;
        prev = 1'b1;
        n = 0;
        for (int i = 0; i < 100; i++) begin
            @(posedge clk);
            #1;
            n++;
            if (mdc && !prev) break;
            prev = mdc;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        csr_read(v);
        chk("R1", "reset status word", 64'(v), 64'h8100_00FF);
        chk("R1", "reset line released", 64'(mdio_oe), 64'h0);
        chk("R1", "reset done low", 64'(usr_done), 64'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        csr_write(32'hFFFF_FFFF);
        csr_read(v);
        chk("R2", "all-ones write readback", 64'(v), 64'hC114_FFFF);
        csr_write(32'h0000_0000);
        csr_read(v);
        chk("R2", "zero write readback", 64'(v), 64'h8100_0000);
        csr_write(ctrl_word(1, 0, 1, 0, 16'h1234));
        csr_read(v);
        chk("R2", "mixed write readback", 64'(v), 64'hC104_1234);
    endtask

    task automatic t_div();
        int n;
        int highs;
        csr_write(ctrl_word(1, 0, 0, 0, 16'd3));
        measure_period(n);
        chk("R3", "MDC period at divider 3", 64'(n), 64'd4);
        csr_write(ctrl_word(1, 0, 0, 0, 16'd4));
        measure_period(n);
        chk("R3", "MDC period at divider 4", 64'(n), 64'd5);
        csr_write(ctrl_word(1, 0, 0, 0, 16'd0));
        highs = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (mdc) highs++;
        end
        chk("R3", "MDC high cycles at divider 0", 64'(highs), 64'd0);
    endtask

    task automatic t_write_pre();
        logic [31:0] f;
        logic [63:0] exp;
        bit seen;
        int width;
        csr_write(ctrl_word(1, 0, 0, 0, 16'd3));
        f = fbits(0, 5'h13, 5'h0A, 16'hA5C3);
        for (int b = 0; b < 64; b++) exp[b] = (b < 32) ? 1'b1 : f[63-b];
        issue_go(0, 5'h13, 5'h0A, 16'hA5C3);
        capture(64, 64'hFFFF_FFFF_FFFF_FFFF);
        wait_done(seen, width);
        chk("R4", "write frame bits with preamble", cap_o, exp);
        chk("R4", "write frame driven throughout", cap_oe, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R12", "done seen after write", 64'(seen), 64'h1);
        chk("R12", "done width", 64'(width), 64'h1);
        chk("R4", "line released after write", 64'(mdio_oe), 64'h0);
    endtask

    task automatic t_read(input bit give_ack, input logic [15:0] d);
        logic [31:0] f;
        logic [63:0] exp;
        logic [63:0] pat;
        logic [63:0] mask;
        bit seen;
        int width;
        csr_write(ctrl_word(1, 1, 0, 0, 16'd3));
        f    = fbits(1, 5'h01, 5'h1F, 16'h0);
        exp  = '0;
        mask = '0;
        pat  = '1;
        for (int b = 0; b < 32; b++) exp[b] = f[31-b];
        for (int b = 0; b < 14; b++) mask[b] = 1'b1;
        pat[15] = give_ack ? 1'b0 : 1'b1;
        for (int k = 0; k < 16; k++) pat[16+k] = d[15-k];
        issue_go(1, 5'h01, 5'h1F, 16'h0);
        capture(32, pat);
        wait_done(seen, width);
        chk("R5", "read header bits without preamble", cap_o & mask, exp & mask);
        chk("R6", "read drive window", cap_oe, mask);
        chk("R6", "read done", 64'(seen), 64'h1);
        chk("R6", "read data", 64'(usr_rdata), 64'(d));
        chk("R6", "read acknowledge", 64'(usr_ack), 64'(give_ack));
    endtask

    task automatic t_write_nopre();
        logic [31:0] f;
        logic [63:0] exp;
        bit seen;
        int width;
        csr_write(ctrl_word(1, 1, 0, 0, 16'd3));
        f = fbits(0, 5'h0C, 5'h11, 16'h5A0F);
        exp = '0;
        for (int b = 0; b < 32; b++) exp[b] = f[31-b];
        issue_go(0, 5'h0C, 5'h11, 16'h5A0F);
        capture(32, 64'hFFFF_FFFF_FFFF_FFFF);
        wait_done(seen, width);
        chk("R5", "write frame bits without preamble", cap_o & 64'hFFFF_FFFF, exp);
        chk("R5", "done after 32 bits", 64'(seen), 64'h1);
    endtask

    task automatic t_disable();
        logic [31:0] v;
        bit seen;
        int width;
        bit oe_seen;
        csr_write(ctrl_word(1, 0, 0, 0, 16'd3));
        issue_go(0, 5'h02, 5'h03, 16'hBEEF);
        wait (mdio_oe === 1'b1);
        csr_write(ctrl_word(0, 0, 0, 0, 16'd3));
        csr_read(v);
        chk("R8", "idle low mid-frame after disable", 64'(v[31]), 64'h0);
        wait_done(seen, width);
        chk("R8", "frame completes after disable", 64'(seen), 64'h1);
        csr_read(v);
        chk("R8", "idle high after frame", 64'(v[31]), 64'h1);
        issue_go(0, 5'h02, 5'h03, 16'h1111);
        oe_seen = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (mdio_oe) oe_seen = 1;
        end
        chk("R7", "go while disabled drives nothing", 64'(oe_seen), 64'h0);
        csr_read(v);
        chk("R7", "still idle after ignored go", 64'(v[31]), 64'h1);
    endtask

    task automatic t_fault();
        logic [31:0] v;
        bit seen;
        csr_write(ctrl_word(1, 1, 1, 0, 16'd3));
        issue_go(0, 5'h04, 5'h05, 16'h0F0F);
        wait (mdio_oe === 1'b1);
        #1;
        inj  = 1'b1;
        seen = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (usr_done) seen = 1;
        end
        inj = 1'b0;
        chk("R9", "no done after fault", 64'(seen), 64'h0);
        chk("R9", "line released after fault", 64'(mdio_oe), 64'h0);
        csr_read(v);
        chk("R9", "fault flag set", 64'(v[19]), 64'h1);
        chk("R9", "idle after fault", 64'(v[31]), 64'h1);
        csr_write(ctrl_word(1, 1, 1, 0, 16'd3));
        csr_read(v);
        chk("R10", "zero write keeps fault", 64'(v[19]), 64'h1);
        csr_write(ctrl_word(1, 1, 1, 1, 16'd3));
        csr_read(v);
        chk("R10", "one write clears fault", 64'(v[19]), 64'h0);
    endtask

    task automatic t_fault_off();
        logic [31:0] v;
        bit seen;
        int width;
        csr_write(ctrl_word(1, 1, 0, 0, 16'd3));
        issue_go(0, 5'h06, 5'h07, 16'h3333);
        wait (mdio_oe === 1'b1);
        #1;
        inj = 1'b1;
        wait_done(seen, width);
        inj = 1'b0;
        chk("R11", "frame completes with detection off", 64'(seen), 64'h1);
        csr_read(v);
        chk("R11", "fault stays clear", 64'(v[19]), 64'h0);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_div();
        t_write_pre();
        t_read(1, 16'h3C96);
        t_read(0, 16'h0F0F);
        t_write_nopre();
        t_disable();
        t_fault();
        t_fault_off();
        finish_run();
    end

    initial begin
        #(4 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule